// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is the clocked control front end of a pipelined burst static RAM organised as 256K words of 32 bits. On every rising clock edge it samples three chip selects, two address strobes (one meant for a processor, one for a cache controller), an advance input and the write controls. From these it keeps a registered word address, made of an upper-address register and a 2-bit burst counter seeded from the low address bits. It also registers the per-byte write enables, a read strobe and the drive decision for the read data.

A behavioural word array sits behind the registered controls. It is built so that block RAM can be inferred, and it stores the low `ARRAY_AW` bits of the word address. A read returns its data one cycle after the address is registered. The data is driven only while the asynchronous output enable is low. On the first beat of a read that starts from the deselected state, the drive is held off. A static mode input chooses between a linear burst order and an interleaved (XOR) burst order.

Top module: `sburst_front`

## Requirements
- R1: The part is selected only when sel1_n=0, sel2=1 and sel3_n=0. An accepted strobe with any select inactive deselects the part. While deselected, no access is issued (rd_stb=0, lane_we=0), and adv_n has no effect until the next selecting strobe.
- R2: When astb_p_n and astb_c_n are both low while sel1_n=0, only the processor strobe is acted on. A processor-strobe cycle is always a read (lane_we=0, rd_stb=1), whatever the write controls are.
- R3: astb_p_n is ignored while sel1_n=1. If astb_c_n is also high in that cycle, a running burst continues as a plain non-strobe cycle.
- R4: On an accepted selecting strobe, addr is loaded as a whole. word_addr shows it after that edge: bits [17:2] come from the upper-address register and bits [1:0] from the burst counter.
- R5: With burst_mode=0 (linear), every non-strobe cycle with adv_n=0 during a burst moves the low two bits to start+n mod 4, where n is the number of advances. The upper 16 bits stay unchanged.
- R6: With burst_mode=1 (interleaved), the low two bits become start XOR n, with n counting 0,1,2,3 and wrapping.
- R7: A non-strobe cycle with adv_n=1 during a burst repeats the access at the current word_addr.
- R8: With gwr_n=0, a write cycle enables all four lanes (lane_we=4'hF), whatever bwe_n and bw_n are.
- R9: With gwr_n=1, lane i is written only when bwe_n=0 and bw_n[i]=0. Lane i is data bits [8i+7:8i]. A cycle with no lane enabled is a read. Write data is sampled on the same edge as the lane enables.
- R10: After the edge that registers a read (rd_stb=1), the next edge places the addressed word on rdata. That word includes every write registered before the read.
- R11: rdata_oe is high only while oe_n is low, and only in the cycle after a read's data has been loaded. It follows oe_n without waiting for a clock.
- R12: On the first data beat of a read loaded from the deselected state, rdata_oe stays low. Reset counts as the deselected state. Later beats of the same burst are driven.
- R13: After reset, word_addr=0, lane_we=0, rd_stb=0 and rdata_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| astb_p_n | input | 1 | Processor address strobe, active low, has priority |
| astb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | LANES | Per-lane byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | DATA_W | Write data |
| burst_mode | input | 1 | 0 linear, 1 interleaved burst order |
| word_addr | output | ADDR_W | Registered internal word address |
| lane_we | output | LANES | Registered per-lane write enables |
| rd_stb | output | 1 | Registered read strobe |
| rdata | output | DATA_W | Read data from the array |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The bench builds the block with its default parameters: an 18-bit address, 32-bit data in four byte lanes, and an 8-bit array index. The upper address bits can therefore take any random value while the 256-word array is filled completely at the start. Aliasing between bursts then happens often, and every read compares against known data. Each burst-order wrap, both strobe priorities and the deselect-then-read masking are reached within a few thousand cycles.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  // Low address bits for beat n of a burst that started at s
  function automatic logic [1:0] beat_ofs(logic [1:0] s, logic [1:0] n, burst_ord_e o);
    return (o == ORD_XOR) ? (s ^ n) : (s + n);
  endfunction
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode (
  input  logic sel1_n,
  input  logic sel2,
  input  logic sel3_n,
  input  logic astb_p_n,
  input  logic astb_c_n,
  output logic sel_ok,
  output logic p_take,
  output logic strobe
);
  always_comb begin
    sel_ok = !sel1_n && sel2 && !sel3_n;
    p_take = !astb_p_n && !sel1_n;
    strobe = p_take || !astb_c_n;
  end
endmodule

// File: rtl/sbc_burst_ctr.sv
module sbc_burst_ctr
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              sel_ok,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  burst_ord_e        mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic              acc,
  output logic              first,
  output logic              active
);
  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] base_q;
  logic [1:0]      start_q, cnt_q;
  logic            desel_q, load;

  always_comb begin
    load  = strobe && sel_ok;
    acc   = load || (!strobe && active);
    first = load && desel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      active  <= 1'b0;
      desel_q <= 1'b1;
    end else if (load) begin
      base_q  <= addr[ADDR_W-1:2];
      start_q <= addr[1:0];
      cnt_q   <= '0;
      active  <= 1'b1;
      desel_q <= 1'b0;
    end else if (strobe) begin
      active  <= 1'b0;
      desel_q <= 1'b1;
    end else if (active && !adv_n) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign word_addr = {base_q, beat_ofs(start_q, cnt_q, mode)};

  a_r5_upper_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (active && !strobe && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe && adv_n) |=> $stable(cnt_q));
endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [AW-1:0]           a,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*LANE_W-1:0] wd,
  input  logic                    re,
  output logic [LANES*LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [LANES*LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (we[i]) mem[a][i*LANE_W +: LANE_W] <= wd[i*LANE_W +: LANE_W];
    if (re) rd <= mem[a];
  end
endmodule

// File: rtl/sburst_front.sv
module sburst_front
  import sbc_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 32,
  parameter int LANES    = 4,
  parameter int ARRAY_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              astb_p_n,
  input  logic              astb_c_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gwr_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              burst_mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              rd_stb,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int LANE_W = DATA_W / LANES;

  logic sel_ok, p_take, strobe, acc, first, active;
  logic [LANES-1:0]  lanes_c;
  logic              is_wr;
  logic [DATA_W-1:0] wd_q;
  logic              first_q, beat_q, mask_q;

  sbc_decode u_dec (
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .astb_p_n(astb_p_n), .astb_c_n(astb_c_n),
    .sel_ok(sel_ok), .p_take(p_take), .strobe(strobe)
  );

  sbc_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .strobe(strobe), .sel_ok(sel_ok), .adv_n(adv_n),
    .addr(addr), .mode(burst_ord_e'(burst_mode)), .word_addr(word_addr),
    .acc(acc), .first(first), .active(active)
  );

  always_comb begin
    if (!gwr_n)      lanes_c = '1;
    else if (!bwe_n) lanes_c = ~bw_n;
    else             lanes_c = '0;
    is_wr = acc && !p_take && (lanes_c != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_we <= '0;
      rd_stb  <= 1'b0;
      first_q <= 1'b0;
      beat_q  <= 1'b0;
      mask_q  <= 1'b0;
      wd_q    <= '0;
    end else begin
      lane_we <= is_wr ? lanes_c : '0;
      rd_stb  <= acc && !is_wr;
      first_q <= first && !is_wr;
      wd_q    <= wdata;
      beat_q  <= rd_stb;
      mask_q  <= rd_stb && first_q;
    end
  end

  sbc_array #(.AW(ARRAY_AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .a(word_addr[ARRAY_AW-1:0]), .we(lane_we), .wd(wd_q),
    .re(rd_stb), .rd(rdata)
  );

  assign rdata_oe = !oe_n && beat_q && !mask_q;

  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    (strobe && !sel_ok) |=> (!rd_stb && lane_we == '0));
  a_r1_adv_ignored: assert property (@(posedge clk) disable iff (rst)
    (!active && !strobe) |=> (!rd_stb && lane_we == '0));
  a_r2_proc_reads: assert property (@(posedge clk) disable iff (rst)
    p_take |=> (lane_we == '0));
  a_r8_global_all: assert property (@(posedge clk) disable iff (rst)
    (acc && !p_take && !gwr_n) |=> (lane_we == '1));
  a_r12_first_masked: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && first_q) |=> !rdata_oe);
  a_r11_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rdata_oe);
endmodule

// File: tb/sburst_front_tb.sv
module sburst_front_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sel1_n = 1, sel2 = 0, sel3_n = 1, ap_n = 1, ac_n = 1, adv_n = 1;
  logic gw_n = 1, bwe_n = 1, oe_n = 1, mode = 0;
  logic [3:0]  bw_n = 4'hF;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [17:0] word_addr;
  logic [3:0]  lane_we;
  logic        rd_stb, rdata_oe;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sburst_front dut_i (
    .clk(clk), .rst(rst), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .astb_p_n(ap_n), .astb_c_n(ac_n), .adv_n(adv_n), .addr(addr),
    .gwr_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata),
    .burst_mode(mode), .word_addr(word_addr), .lane_we(lane_we),
    .rd_stb(rd_stb), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // reference state
  logic        m_act = 0, m_des = 1;
  logic [15:0] m_base = '0;
  logic [1:0]  m_st = '0, m_cnt = '0;
  logic [31:0] mm [256];
  logic        p_vld = 0, p_first = 0;
  logic [7:0]  p_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic sok, pt, str, ld, acc, wr, fst;
    logic [3:0] ln;
    logic [17:0] ea;
    sok = !sel1_n && sel2 && !sel3_n;
    pt  = !ap_n && !sel1_n;
    str = pt || !ac_n;
    ld  = str && sok;
    acc = ld || (!str && m_act);
    ln  = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
    wr  = acc && !pt && (ln != 4'h0);
    fst = ld && m_des && !wr;
    if (ld) begin
      m_base = addr[17:2]; m_st = addr[1:0]; m_cnt = 2'd0; m_act = 1; m_des = 0;
    end else if (str) begin
      m_act = 0; m_des = 1;
    end else if (m_act && !adv_n) m_cnt = m_cnt + 2'd1;
    ea = {m_base, (mode ? (m_st ^ m_cnt) : (m_st + m_cnt))};
    @(posedge clk);
    @(negedge clk);
    if (acc) chk(word_addr === ea, "R4 word_addr", 32'(word_addr), 32'(ea));
    chk(lane_we === (wr ? ln : 4'h0), (!gw_n ? "R8 lane_we" : "R9 lane_we"),
        32'(lane_we), 32'(wr ? ln : 4'h0));
    chk(rd_stb === (acc && !wr), "R1 rd_stb", 32'(rd_stb), 32'(acc && !wr));
    if (p_vld) begin
      chk(rdata === mm[p_addr], "R10 rdata", rdata, mm[p_addr]);
      chk(rdata_oe === (!oe_n && !p_first), "R12 rdata_oe", 32'(rdata_oe),
          32'(!oe_n && !p_first));
    end else chk(rdata_oe === 1'b0, "R11 rdata_oe idle", 32'(rdata_oe), 32'd0);
    if (wr)
      for (int i = 0; i < 4; i++)
        if (ln[i]) mm[ea[7:0]][i*8 +: 8] = wdata[i*8 +: 8];
    p_vld = acc && !wr; p_first = fst; p_addr = ea[7:0];
  endtask

  task automatic idle();
    sel1_n = 0; sel2 = 1; sel3_n = 0; ap_n = 1; ac_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(word_addr === '0, "R13 word_addr", 32'(word_addr), 0);
    chk(lane_we === '0, "R13 lane_we", 32'(lane_we), 0);
    chk(rd_stb === 1'b0, "R13 rd_stb", 32'(rd_stb), 0);
    chk(rdata_oe === 1'b0, "R13 rdata_oe", 32'(rdata_oe), 0);
    rst = 0;

    // fill the array with global-write bursts
    for (int b = 0; b < 64; b++) begin
      idle(); ac_n = 0; gw_n = 0; addr = {$urandom_range(1023, 0), b[5:0], 2'b00};
      wdata = $urandom(); tick();
      ac_n = 1; adv_n = 0;
      for (int k = 0; k < 3; k++) begin wdata = $urandom(); tick(); end
    end

    // R5: linear order from start 3
    idle(); mode = 0; ac_n = 0; addr = 18'h00103; tick();
    chk(word_addr === 18'h00103, "R5 load", 32'(word_addr), 32'h103);
    ac_n = 1; adv_n = 0;
    tick(); chk(word_addr === 18'h00100, "R5 beat1", 32'(word_addr), 32'h100);
    tick(); chk(word_addr === 18'h00101, "R5 beat2", 32'(word_addr), 32'h101);
    tick(); chk(word_addr === 18'h00102, "R5 beat3", 32'(word_addr), 32'h102);
    tick(); chk(word_addr === 18'h00103, "R5 wrap", 32'(word_addr), 32'h103);

    // R6: interleaved order from start 2, then R7 hold
    idle(); mode = 1; ac_n = 0; addr = 18'h2A5E6; tick();
    ac_n = 1; adv_n = 0;
    tick(); chk(word_addr === 18'h2A5E7, "R6 beat1", 32'(word_addr), 32'h2A5E7);
    tick(); chk(word_addr === 18'h2A5E4, "R6 beat2", 32'(word_addr), 32'h2A5E4);
    tick(); chk(word_addr === 18'h2A5E5, "R6 beat3", 32'(word_addr), 32'h2A5E5);
    adv_n = 1;
    tick(); chk(word_addr === 18'h2A5E5, "R7 hold", 32'(word_addr), 32'h2A5E5);
    chk(rd_stb === 1'b1, "R7 repeat access", 32'(rd_stb), 1);

    // R2: both strobes with global write -> processor read
    idle(); mode = 0; ap_n = 0; ac_n = 0; gw_n = 0; addr = 18'h00010; tick();
    chk(lane_we === 4'h0 && rd_stb === 1'b1, "R2 proc priority", 32'({lane_we, rd_stb}), 32'h01);

    // R3: processor strobe ignored with sel1_n high -> continuation
    idle(); ap_n = 0; sel1_n = 1; adv_n = 0; tick();
    chk(word_addr === 18'h00011, "R3 continue", 32'(word_addr), 32'h11);

    // R1: deselect, then advance has no effect
    idle(); sel2 = 0; ac_n = 0; tick();
    chk(rd_stb === 1'b0, "R1 deselect", 32'(rd_stb), 0);
    idle(); adv_n = 0; gw_n = 0; tick();
    chk(lane_we === 4'h0 && rd_stb === 1'b0, "R1 adv ignored", 32'({lane_we, rd_stb}), 0);

    // R12: first read beat after deselect is not driven
    idle(); oe_n = 0; ac_n = 0; addr = 18'h00005; tick();
    ac_n = 1; adv_n = 0; tick();
    chk(rdata_oe === 1'b0, "R12 first masked", 32'(rdata_oe), 0);
    tick();
    chk(rdata_oe === 1'b1, "R12 second driven", 32'(rdata_oe), 1);

    // R9: byte lanes
    idle(); ac_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 18'h00020; wdata = 32'hA1B2C3D4; tick();
    chk(lane_we === 4'b0101, "R9 byte lanes", 32'(lane_we), 32'h5);

    // constrained random, linear then interleaved
    for (int ph = 0; ph < 2; ph++) begin
      mode = ph[0];
      for (int n = 0; n < 2000; n++) begin
        sel1_n = ($urandom_range(7, 0) == 0);
        sel2   = ($urandom_range(7, 0) != 0);
        sel3_n = ($urandom_range(7, 0) == 0);
        ap_n   = ($urandom_range(3, 0) != 0);
        ac_n   = ($urandom_range(3, 0) != 0);
        adv_n  = $urandom_range(1, 0) == 1;
        gw_n   = ($urandom_range(5, 0) != 0);
        bwe_n  = $urandom_range(1, 0) == 1;
        bw_n   = 4'($urandom());
        oe_n   = ($urandom_range(3, 0) == 0);
        addr   = 18'($urandom());
        wdata  = $urandom();
        tick();
      end
    end
    idle(); tick();
    finish_run();
  end
endmodule